// File: doc/BRIEF.md
# Floating-Point Exponent and Shift Datapath

This block is the exponent side of a multi-cycle floating-point unit. It holds two registers: the working result exponent and the working shift count. A sequencing state machine outside the block drives a set of select and negate controls every cycle. Each register's next value comes from a two-operand adder whose inputs are picked by multiplexers. The exponent adder can take the operand exponents, the register contents and a small set of constants. The shift adder can take similar sources and a longer list of shift constants.

Either adder input may be negated, but never both at once. A leading-zero count from the mantissa normaliser can go straight into the shift register. It is selected after the shift adder, so it never passes through that adder. The controls are a flat set of fields, so a microcode table could drive them later without any change to the block.

Top module: `fpx_exp_shift`

## Requirements
- R1: While `rst_ni` is low, both `res_exp_o` and `shift_o` are 0.
- R2: All exponent values are 13-bit two's complement and wrap modulo 2^13. Each register shows its new value on the clock edge after the controls are applied. When `re_set_i` is 1, the next `res_exp_o` is op1 + op2. Op1 is negated if `re_neg1_i` is 1, and op2 is negated if `re_neg2_i` is 1.
- R3: `re_op1_sel_i` selects exponent op1: 0 = current result exponent, 1 = A exponent, 2 = B exponent arithmetically shifted right by one, 3 = zero.
- R4: `re_op2_sel_i` selects exponent op2: 0 = result exponent minus shift (current register values), 1 = B exponent, 2 = C exponent, 3 = the constant chosen by `re_const_sel_i`.
- R5: `re_const_sel_i` selects the exponent constant: 0 = 0, 1 = 56, 2 = 1023 (largest exponent), 3 = 1536 (trap-enabled overflow bias).
- R6: When `re_set_i` is 0, `res_exp_o` keeps its value, whatever the other exponent controls are.
- R7: `sh_op1_sel_i` selects shift op1: 0 = result exponent minus shift, 1 = B exponent, 2 = current shift, 3 = zero.
- R8: `sh_op2_sel_i` selects shift op2: 0 = A exponent, 1 = the constant chosen by `sh_const_sel_i`. The shift register loads its next value on every clock edge.
- R9: `sh_const_sel_i` selects the shift constant: 0..9 give 0, 1, 4, 8, 32, 52, 56, 63, 64, -1022. Codes 10..15 give 0.
- R10: When `sh_use_lzc_i` is 1, the next `shift_o` is `lzc_i` zero-extended, whatever the shift adder controls are.
- R11: In the shift adder, op1 is negated if `sh_neg1_i` is 1 and op2 is negated if `sh_neg2_i` is 1. Setting both negate controls of the same adder in the same cycle is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_exp_i | input | 13 | A operand exponent |
| b_exp_i | input | 13 | B operand exponent |
| c_exp_i | input | 13 | C operand exponent |
| lzc_i | input | 7 | Leading-zero count of the mantissa |
| re_op1_sel_i | input | 2 | Exponent op1 select |
| re_neg1_i | input | 1 | Negate exponent op1 |
| re_op2_sel_i | input | 2 | Exponent op2 select |
| re_neg2_i | input | 1 | Negate exponent op2 |
| re_const_sel_i | input | 2 | Exponent constant select |
| re_set_i | input | 1 | Load the result exponent register |
| sh_op1_sel_i | input | 2 | Shift op1 select |
| sh_neg1_i | input | 1 | Negate shift op1 |
| sh_op2_sel_i | input | 1 | Shift op2 select |
| sh_neg2_i | input | 1 | Negate shift op2 |
| sh_const_sel_i | input | 4 | Shift constant select |
| sh_use_lzc_i | input | 1 | Load the leading-zero count into shift |
| res_exp_o | output | 13 | Result exponent register |
| shift_o | output | 13 | Shift count register |

## Verification
Both registers drive outputs directly, so a wrong select decode, a wrong constant or a faulty negation shows on `res_exp_o` or `shift_o` one edge after the controls are applied. Both registers also feed back through the result-exponent-minus-shift source. A bad value therefore spreads into the other register on the next cycle that uses that source. The bench runs a reference model on every cycle and compares both outputs, so each error is caught on the cycle it first appears.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {E1_RES = 2'd0, E1_A = 2'd1, E1_BHALF = 2'd2, E1_ZERO = 2'd3} exp_src1_e;
  typedef enum logic [1:0] {E2_DIFF = 2'd0, E2_B = 2'd1, E2_C = 2'd2, E2_CONST = 2'd3} exp_src2_e;
  typedef enum logic [1:0] {S1_DIFF = 2'd0, S1_B = 2'd1, S1_SHIFT = 2'd2, S1_ZERO = 2'd3} sh_src1_e;
  typedef enum logic {S2_A = 1'b0, S2_CONST = 1'b1} sh_src2_e;

  function automatic int sh_const(input logic [3:0] code, input int emin);
    case (code)
      4'd0: return 0;
      4'd1: return 1;
      4'd2: return 4;
      4'd3: return 8;
      4'd4: return 32;
      4'd5: return 52;
      4'd6: return 56;
      4'd7: return 63;
      4'd8: return 64;
      4'd9: return emin;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_const(input logic [1:0] code, input int emax, input int bias);
    case (code)
      2'd0: return 0;
      2'd1: return 56;
      2'd2: return emax;
      default: return bias;
    endcase
  endfunction
endpackage

// File: rtl/fpx_add2.sv
module fpx_add2 #(
  parameter int W = 13
) (
  input  logic [W-1:0] op1_i,
  input  logic         neg1_i,
  input  logic [W-1:0] op2_i,
  input  logic         neg2_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] t1, t2, cin;
  // two's complement negate: invert and add one through the carry terms
  assign t1    = op1_i ^ {W{neg1_i}};
  assign t2    = op2_i ^ {W{neg2_i}};
  assign cin   = W'(neg1_i) + W'(neg2_i);
  assign sum_o = t1 + t2 + cin;
endmodule

// File: rtl/fpx_exp_sel.sv
module fpx_exp_sel #(
  parameter int W    = 13,
  parameter int EMAX = 1023,
  parameter int BIAS = 1536
) (
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] diff_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [1:0]   sel1_i,
  input  logic [1:0]   sel2_i,
  input  logic [1:0]   csel_i,
  output logic [W-1:0] op1_o,
  output logic [W-1:0] op2_o
);
  import fpx_pkg::*;
  logic [W-1:0] kval;
  always_comb kval = W'(exp_const(csel_i, EMAX, BIAS));

  always_comb begin
    case (exp_src1_e'(sel1_i))
      E1_RES:   op1_o = res_i;
      E1_A:     op1_o = a_i;
      E1_BHALF: op1_o = {b_i[W-1], b_i[W-1:1]};
      default:  op1_o = '0;
    endcase
    case (exp_src2_e'(sel2_i))
      E2_DIFF: op2_o = diff_i;
      E2_B:    op2_o = b_i;
      E2_C:    op2_o = c_i;
      default: op2_o = kval;
    endcase
  end
endmodule

// File: rtl/fpx_shift_sel.sv
module fpx_shift_sel #(
  parameter int W    = 13,
  parameter int EMIN = -1022
) (
  input  logic [W-1:0] diff_i,
  input  logic [W-1:0] shift_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel1_i,
  input  logic         sel2_i,
  input  logic [3:0]   csel_i,
  output logic [W-1:0] op1_o,
  output logic [W-1:0] op2_o
);
  import fpx_pkg::*;
  logic [W-1:0] kval;
  always_comb kval = W'(sh_const(csel_i, EMIN));

  always_comb begin
    case (sh_src1_e'(sel1_i))
      S1_DIFF:  op1_o = diff_i;
      S1_B:     op1_o = b_i;
      S1_SHIFT: op1_o = shift_i;
      default:  op1_o = '0;
    endcase
    op2_o = (sh_src2_e'(sel2_i) == S2_CONST) ? kval : a_i;
  end
endmodule

// File: rtl/fpx_exp_shift.sv
module fpx_exp_shift #(
  parameter int EXP_W    = 13,
  parameter int LZC_W    = 7,
  parameter int EXP_MAX  = 1023,
  parameter int EXP_MIN  = -1022,
  parameter int OVF_BIAS = 1536
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic [EXP_W-1:0] c_exp_i,
  input  logic [LZC_W-1:0] lzc_i,
  input  logic [1:0]       re_op1_sel_i,
  input  logic             re_neg1_i,
  input  logic [1:0]       re_op2_sel_i,
  input  logic             re_neg2_i,
  input  logic [1:0]       re_const_sel_i,
  input  logic             re_set_i,
  input  logic [1:0]       sh_op1_sel_i,
  input  logic             sh_neg1_i,
  input  logic             sh_op2_sel_i,
  input  logic             sh_neg2_i,
  input  logic [3:0]       sh_const_sel_i,
  input  logic             sh_use_lzc_i,
  output logic [EXP_W-1:0] res_exp_o,
  output logic [EXP_W-1:0] shift_o
);
  localparam int PAD_W = EXP_W - LZC_W;

  logic [EXP_W-1:0] res_q, sh_q, diff;
  logic [EXP_W-1:0] e_op1, e_op2, e_sum;
  logic [EXP_W-1:0] s_op1, s_op2, s_sum, s_next;

  assign diff = res_q - sh_q;

  fpx_exp_sel #(.W(EXP_W), .EMAX(EXP_MAX), .BIAS(OVF_BIAS)) u_esel (
    .res_i(res_q), .diff_i(diff), .a_i(a_exp_i), .b_i(b_exp_i), .c_i(c_exp_i),
    .sel1_i(re_op1_sel_i), .sel2_i(re_op2_sel_i), .csel_i(re_const_sel_i),
    .op1_o(e_op1), .op2_o(e_op2)
  );

  fpx_shift_sel #(.W(EXP_W), .EMIN(EXP_MIN)) u_ssel (
    .diff_i(diff), .shift_i(sh_q), .a_i(a_exp_i), .b_i(b_exp_i),
    .sel1_i(sh_op1_sel_i), .sel2_i(sh_op2_sel_i), .csel_i(sh_const_sel_i),
    .op1_o(s_op1), .op2_o(s_op2)
  );

  fpx_add2 #(.W(EXP_W)) u_eadd (
    .op1_i(e_op1), .neg1_i(re_neg1_i), .op2_i(e_op2), .neg2_i(re_neg2_i), .sum_o(e_sum)
  );

  fpx_add2 #(.W(EXP_W)) u_sadd (
    .op1_i(s_op1), .neg1_i(sh_neg1_i), .op2_i(s_op2), .neg2_i(sh_neg2_i), .sum_o(s_sum)
  );

  // leading-zero count joins after the adder to keep it off the carry chain
  generate
    if (PAD_W > 0) begin : g_pad
      assign s_next = sh_use_lzc_i ? {{PAD_W{1'b0}}, lzc_i} : s_sum;
    end else begin : g_nopad
      assign s_next = sh_use_lzc_i ? lzc_i[EXP_W-1:0] : s_sum;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      sh_q  <= '0;
    end else begin
      if (re_set_i) res_q <= e_sum;
      sh_q <= s_next;
    end
  end

  assign res_exp_o = res_q;
  assign shift_o   = sh_q;
endmodule

// File: rtl/fpx_exp_shift_chk.sv
module fpx_exp_shift_chk #(
  parameter int EXP_W = 13,
  parameter int LZC_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [EXP_W-1:0] a_exp_i,
  input logic [EXP_W-1:0] b_exp_i,
  input logic [LZC_W-1:0] lzc_i,
  input logic [1:0]       re_op1_sel_i,
  input logic             re_neg1_i,
  input logic [1:0]       re_op2_sel_i,
  input logic             re_neg2_i,
  input logic             re_set_i,
  input logic             sh_neg1_i,
  input logic             sh_neg2_i,
  input logic             sh_use_lzc_i,
  input logic [EXP_W-1:0] res_exp_o,
  input logic [EXP_W-1:0] shift_o
);
  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_zero: assert (res_exp_o == '0 && shift_o == '0);

  a_r11_exp_neg_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_neg1_i && re_neg2_i));

  a_r11_sh_neg_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sh_neg1_i && sh_neg2_i));

  a_r6_exp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_set_i |=> $stable(res_exp_o));

  a_r10_lzc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_use_lzc_i |=> shift_o == EXP_W'($past(lzc_i)));

  a_r2_a_plus_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_set_i && re_op1_sel_i == 2'd1 && re_op2_sel_i == 2'd1 && !re_neg1_i && !re_neg2_i)
    |=> res_exp_o == $past(a_exp_i + b_exp_i));
endmodule

bind fpx_exp_shift fpx_exp_shift_chk #(.EXP_W(EXP_W), .LZC_W(LZC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_exp_i(a_exp_i), .b_exp_i(b_exp_i), .lzc_i(lzc_i),
  .re_op1_sel_i(re_op1_sel_i), .re_neg1_i(re_neg1_i), .re_op2_sel_i(re_op2_sel_i),
  .re_neg2_i(re_neg2_i), .re_set_i(re_set_i), .sh_neg1_i(sh_neg1_i), .sh_neg2_i(sh_neg2_i),
  .sh_use_lzc_i(sh_use_lzc_i), .res_exp_o(res_exp_o), .shift_o(shift_o)
);

// File: tb/sim_fpx_exp_shift.sv
`timescale 1ns/1ps
module sim_fpx_exp_shift;
  localparam int W = 13;
  localparam int LW = 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic [W-1:0] a, b, c;
  logic [LW-1:0] lzc;
  logic [1:0] re_s1, re_s2, re_k;
  logic re_n1, re_n2, re_set;
  logic [1:0] sh_s1;
  logic sh_s2, sh_n1, sh_n2, sh_lz;
  logic [3:0] sh_k;
  logic [W-1:0] res_exp_o, shift_o;
  logic [W-1:0] m_exp, m_sh;
  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  fpx_exp_shift u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_exp_i(a), .b_exp_i(b), .c_exp_i(c), .lzc_i(lzc),
    .re_op1_sel_i(re_s1), .re_neg1_i(re_n1), .re_op2_sel_i(re_s2), .re_neg2_i(re_n2),
    .re_const_sel_i(re_k), .re_set_i(re_set), .sh_op1_sel_i(sh_s1), .sh_neg1_i(sh_n1),
    .sh_op2_sel_i(sh_s2), .sh_neg2_i(sh_n2), .sh_const_sel_i(sh_k), .sh_use_lzc_i(sh_lz),
    .res_exp_o(res_exp_o), .shift_o(shift_o)
  );

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, $signed(act), $signed(exp));
    end
  endtask

  function automatic logic [W-1:0] ek(logic [1:0] k);
    case (k)
      2'd0: return 13'd0;
      2'd1: return 13'd56;
      2'd2: return 13'd1023;
      default: return 13'd1536;
    endcase
  endfunction

  function automatic logic [W-1:0] sk(logic [3:0] k);
    case (k)
      4'd1: return 13'd1;
      4'd2: return 13'd4;
      4'd3: return 13'd8;
      4'd4: return 13'd32;
      4'd5: return 13'd52;
      4'd6: return 13'd56;
      4'd7: return 13'd63;
      4'd8: return 13'd64;
      4'd9: return -13'sd1022;
      default: return 13'd0;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_next();
    logic [W-1:0] o1, o2;
    case (re_s1)
      2'd0: o1 = m_exp;
      2'd1: o1 = a;
      2'd2: o1 = {b[W-1], b[W-1:1]};
      default: o1 = '0;
    endcase
    case (re_s2)
      2'd0: o2 = m_exp - m_sh;
      2'd1: o2 = b;
      2'd2: o2 = c;
      default: o2 = ek(re_k);
    endcase
    if (re_n1) o1 = -o1;
    if (re_n2) o2 = -o2;
    return re_set ? o1 + o2 : m_exp;
  endfunction

  function automatic logic [W-1:0] sh_next();
    logic [W-1:0] o1, o2;
    if (sh_lz) return W'(lzc);
    case (sh_s1)
      2'd0: o1 = m_exp - m_sh;
      2'd1: o1 = b;
      2'd2: o1 = m_sh;
      default: o1 = '0;
    endcase
    o2 = sh_s2 ? sk(sh_k) : a;
    if (sh_n1) o1 = -o1;
    if (sh_n2) o2 = -o2;
    return o1 + o2;
  endfunction

  task automatic set_e(logic [1:0] s1, logic n1, logic [1:0] s2, logic n2, logic [1:0] k, logic st);
    re_s1 = s1; re_n1 = n1; re_s2 = s2; re_n2 = n2; re_k = k; re_set = st;
  endtask

  task automatic set_s(logic [1:0] s1, logic n1, logic s2, logic n2, logic [3:0] k, logic lz);
    sh_s1 = s1; sh_n1 = n1; sh_s2 = s2; sh_n2 = n2; sh_k = k; sh_lz = lz;
  endtask

  // one clock with the inputs as set; compare both registers after the edge
  task automatic step(string req);
    logic [W-1:0] ne, ns;
    ne = exp_next();
    ns = sh_next();
    @(posedge clk_i);
    @(negedge clk_i);
    m_exp = ne;
    m_sh  = ns;
    chk(req, "res_exp", res_exp_o, m_exp);
    chk(req, "shift", shift_o, m_sh);
  endtask

  task automatic t_reset();
    chk("R1", "res_exp", res_exp_o, '0);
    chk("R1", "shift", shift_o, '0);
  endtask

  task automatic t_exp_op1();
    a = 13'd100; b = -13'sd41; c = 13'd7;
    set_s(2'd2, 0, 1'b1, 0, 4'd0, 0);
    set_e(2'd1, 0, 2'd3, 0, 2'd0, 1); step("R3");
    set_e(2'd0, 0, 2'd3, 0, 2'd0, 1); step("R3");
    set_e(2'd2, 0, 2'd3, 0, 2'd0, 1); step("R3");
    set_e(2'd3, 0, 2'd3, 0, 2'd1, 1); step("R3");
  endtask

  task automatic t_exp_op2();
    set_s(2'd3, 0, 1'b1, 0, 4'd3, 0); set_e(2'd1, 0, 2'd3, 0, 2'd0, 1); step("R4");
    set_s(2'd2, 0, 1'b1, 0, 4'd0, 0);
    set_e(2'd0, 0, 2'd0, 0, 2'd0, 1); step("R4");
    set_e(2'd3, 0, 2'd1, 0, 2'd0, 1); step("R4");
    set_e(2'd3, 0, 2'd2, 0, 2'd0, 1); step("R4");
  endtask

  task automatic t_exp_const();
    for (int k = 0; k < 4; k++) begin
      set_e(2'd3, 0, 2'd3, 0, 2'(k), 1); step("R5");
    end
  endtask

  task automatic t_exp_neg();
    a = 13'd4000; b = 13'd300; c = -13'sd12;
    set_e(2'd1, 0, 2'd3, 0, 2'd3, 1); step("R2");
    set_e(2'd1, 1, 2'd1, 0, 2'd0, 1); step("R2");
    set_e(2'd1, 0, 2'd2, 1, 2'd0, 1); step("R2");
    set_e(2'd0, 1, 2'd3, 0, 2'd2, 1); step("R2");
  endtask

  task automatic t_exp_hold();
    set_e(2'd1, 0, 2'd1, 0, 2'd0, 1); step("R6");
    set_e(2'd3, 1, 2'd3, 0, 2'd3, 0); step("R6");
    a = 13'd9; set_e(2'd1, 0, 2'd2, 1, 2'd1, 0); step("R6");
    chk("R6", "res_exp held", res_exp_o, 13'd4300);
  endtask

  task automatic t_shift_src();
    a = 13'd20; b = -13'sd6;
    set_e(2'd1, 0, 2'd3, 0, 2'd0, 0);
    set_s(2'd1, 0, 1'b0, 0, 4'd0, 0); step("R7");
    set_s(2'd2, 0, 1'b0, 0, 4'd0, 0); step("R7");
    set_s(2'd0, 0, 1'b1, 0, 4'd0, 0); step("R7");
    set_s(2'd3, 0, 1'b0, 0, 4'd0, 0); step("R8");
    set_s(2'd3, 0, 1'b1, 0, 4'd6, 0); step("R8");
  endtask

  task automatic t_shift_const();
    for (int k = 0; k < 16; k++) begin
      set_s(2'd3, 0, 1'b1, 0, 4'(k), 0); step("R9");
    end
  endtask

  task automatic t_shift_neg();
    a = 13'd70; b = 13'd5;
    set_s(2'd1, 1, 1'b0, 0, 4'd0, 0); step("R11");
    set_s(2'd1, 0, 1'b0, 1, 4'd0, 0); step("R11");
    set_s(2'd2, 1, 1'b1, 0, 4'd9, 0); step("R11");
  endtask

  task automatic t_lzc();
    lzc = 7'd64; set_s(2'd1, 1, 1'b1, 0, 4'd8, 1); step("R10");
    chk("R10", "shift is lzc", shift_o, 13'd64);
    lzc = 7'd0; set_s(2'd2, 0, 1'b0, 1, 4'd3, 1); step("R10");
    lzc = 7'd127; set_s(2'd0, 0, 1'b1, 0, 4'd1, 1); step("R10");
    set_e(2'd0, 0, 2'd0, 0, 2'd0, 1); set_s(2'd2, 0, 1'b1, 0, 4'd0, 0); step("R10");
  endtask

  initial begin
    a = '0; b = '0; c = '0; lzc = '0;
    set_e(2'd0, 0, 2'd0, 0, 2'd0, 0);
    set_s(2'd0, 0, 1'b0, 0, 4'd0, 0);
    m_exp = '0; m_sh = '0;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    set_s(2'd2, 0, 1'b1, 0, 4'd0, 0);
    step("R1");
    t_exp_op1();
    t_exp_op2();
    t_exp_const();
    t_exp_neg();
    t_exp_hold();
    t_shift_src();
    t_shift_const();
    t_shift_neg();
    t_lzc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule